// File: doc/BRIEF.md
# Format-Aware Pixel FIFO Controller

This block buffers the bytes of scaled pixels between an upstream pixel source and a display timing generator. The source delivers one byte per cycle while the block's fetch request is high. During active video the block pops one whole pixel per cycle, two or three bytes depending on the selected output format, and presents it to the encoder one cycle later.

The fetch request is not a fixed almost-full mark. The request level is derived from the output format so that a set number of pixels can still arrive after the request drops without overrunning the 64-byte store. Control inputs select the format, enable the block, empty the store on command or at each frame start, hold output until the first line start, and choose whether a starved pixel latches a sticky underflow that blanks output until the next frame. One clock is used throughout.

Top module: `pixfifo_ctrl`

## Requirements
- R1: After reset the stored level is 0, fetch_req is low, pix_valid is low and underflow_sticky is low.
- R2: fetch_req is high exactly when the block is enabled, no clear is requested and the stored level is below the request level, which depends on cfg_format: codes 0 and 1 (16-bit) give 52, code 2 (18-bit) gives 50, codes 3 and 4 (24-bit) and every other code give 46.
- R3: A byte on src_byte is stored in a cycle where src_valid and cfg_enable are high and the level is below 64, raising the level by one; at a level of 64 further bytes are dropped and the level stays 64.
- R4: In an enabled active-video cycle with enough stored bytes, one pixel is popped: 2 bytes for format codes 0 and 1, 3 bytes for all other codes. The oldest byte lands in pix_data bits 7:0, the next in bits 15:8, the third in bits 23:16; 2-byte pixels have bits 23:16 zero. pix_valid and pix_data show that pixel after the next clock edge.
- R5: A cycle with cfg_fifo_clear high empties the store; the sequence all-zero, then clear with enable, then all-zero leaves level 0 and fetch_req low.
- R6: With cfg_clear_at_frame high, a frame_start cycle empties the store and a byte offered in that same cycle is discarded; with it low, frame_start leaves the stored bytes in place.
- R7: With cfg_wait_hstart high, after enable or a clear no pixel is popped, pix_valid stays low and no underflow is raised until a line_start cycle has occurred; popping starts in the cycle after line_start.
- R8: With cfg_uf_trigger high, an enabled active-video cycle with too few stored bytes sets underflow_sticky; while it is set pixels are output as zero, nothing is popped, and a frame_start cycle clears it.
- R9: With cfg_uf_trigger low, a starved active-video cycle outputs one zero pixel with pix_valid high, underflow_sticky stays low, and the next pixel is popped normally once bytes are present.
- R10: When a byte is stored and a pixel is popped in the same cycle, the level changes by one minus the pixel's byte count.
- R11: With cfg_enable low, src_valid and video_active have no effect: the level and contents are kept, pix_valid is low and fetch_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Block enable |
| cfg_fifo_clear | input | 1 | Empty the store while high |
| cfg_clear_at_frame | input | 1 | Empty the store on each frame_start |
| cfg_wait_hstart | input | 1 | Hold output until the first line_start |
| cfg_uf_trigger | input | 1 | Starvation latches sticky underflow and blanks output |
| cfg_format | input | 3 | Output pixel format code |
| src_valid | input | 1 | A source byte is offered |
| src_byte | input | 8 | Source byte |
| fetch_req | output | 1 | Request more bytes from the source |
| fifo_level | output | 7 | Stored byte count, 0 to 64 |
| frame_start | input | 1 | One-cycle frame start pulse |
| line_start | input | 1 | One-cycle horizontal start pulse |
| video_active | input | 1 | Active video needs a pixel this cycle |
| pix_valid | output | 1 | pix_data holds a pixel slot |
| pix_data | output | 24 | Output pixel, oldest byte lowest |
| underflow_sticky | output | 1 | Latched underflow |

## Verification
Storing a byte and popping a pixel can fall in the same cycle, and the level must then move by one minus the pixel width rather than by either alone. The bench provokes this by holding src_valid and video_active high together with six bytes stored in a 24-bit format, and judges both the resulting level of four and the packed pixel value. A frame-start clear meeting an offered byte is a second overlap, judged by the level reading zero afterwards.

// File: rtl/pfc_pkg.sv
// Shared format codes and format-derived constants for the pixel FIFO.
// Assumes the 18-bit format needs two bytes more margin than the 16-bit ones.
package pfc_pkg;

    typedef enum logic [2:0] {
        FMT_P16_A = 3'd0,
        FMT_P16_B = 3'd1,
        FMT_P18   = 3'd2,
        FMT_P24_A = 3'd3,
        FMT_P24_B = 3'd4
    } pix_fmt_e;

    // Request level: capacity minus room for LAT pixels still in flight.
    function automatic int unsigned fmt_full_level(input logic [2:0] code,
                                                   input int unsigned depth,
                                                   input int unsigned lat);
        case (code)
            FMT_P16_A, FMT_P16_B: return depth - 2 * lat;
            FMT_P18:              return depth - (2 * lat + 2);
            default:              return depth - 3 * lat;
        endcase
    endfunction

    // Bytes consumed per output pixel.
    function automatic logic [1:0] fmt_pix_bytes(input logic [2:0] code);
        case (code)
            FMT_P16_A, FMT_P16_B: return 2'd2;
            default:              return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pfc_fmt_decode.sv
// Decodes the format code into the fetch request level and the pixel width
// in bytes. Purely combinational; assumes the level fits in CNT_W bits.
module pfc_fmt_decode #(
    parameter int DEPTH = 64,
    parameter int LAT   = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [2:0]       fmt,
    output logic [CNT_W-1:0] full_level,
    output logic [1:0]       pix_bytes
);
    // Table lookup through the shared package functions.
    always_comb begin
        full_level = CNT_W'(pfc_pkg::fmt_full_level(fmt, DEPTH, LAT));
        pix_bytes  = pfc_pkg::fmt_pix_bytes(fmt);
    end
endmodule

// File: rtl/pfc_byte_ring.sv
// Byte ring buffer with single-byte push and multi-byte pop. Exposes the
// TAPS oldest bytes at once. Assumes DEPTH is a power of two so the
// pointers wrap naturally; flush has priority over push and pop.
module pfc_byte_ring #(
    parameter int DEPTH  = 64,
    parameter int BYTE_W = 8,
    parameter int TAPS   = 3,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [BYTE_W-1:0]        push_byte,
    input  logic                     pop,
    input  logic [1:0]               pop_bytes,
    output logic [CNT_W-1:0]         count,
    output logic [TAPS*BYTE_W-1:0]   taps
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push && !flush && (count < CNT_W'(DEPTH));
    assign pop_ok  = pop && !flush;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_byte;
    end

    // Pointer and level update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(pop_bytes);
            count <= count + CNT_W'(push_ok) - (pop_ok ? CNT_W'(pop_bytes) : '0);
        end
    end

    // Oldest bytes, one tap per byte lane.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign taps[t*BYTE_W +: BYTE_W] = mem[rd_ptr + PTR_W'(t)];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R3
    AST_POP_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> (count >= CNT_W'(pop_bytes))); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R5
endmodule

// File: rtl/pfc_pixel_gate.sv
// Decides per cycle whether a pixel is popped, starved or blocked, tracks
// the line-start wait and the sticky underflow, and registers the output
// pixel. Assumes frame_start and line_start are single-cycle pulses.
module pfc_pixel_gate #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear_all,
    input  logic             flush,
    input  logic             wait_cfg,
    input  logic             uf_trig,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             active,
    input  logic             have_pixel,
    input  logic [1:0]       pix_bytes,
    input  logic [PIX_W-1:0] taps,
    output logic             pop,
    output logic             pix_valid,
    output logic [PIX_W-1:0] pix_data,
    output logic             uf_flag
);
    logic             started_q;
    logic             go;
    logic             slot;
    logic             starve;
    logic [PIX_W-1:0] packed_pix;

    assign go     = enable && !clear_all && (started_q || !wait_cfg);
    assign slot   = go && active;
    assign pop    = slot && have_pixel && !uf_flag && !flush;
    assign starve = slot && !have_pixel && !uf_flag && !flush;

    // Blank the top lane for two-byte pixels.
    always_comb begin
        packed_pix = taps;
        if (pix_bytes == 2'd2) packed_pix[PIX_W-1 -: 8] = '0;
    end

    // Line-start wait: armed by disable or clear, released by line_start.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || clear_all) started_q <= 1'b0;
        else if (line_start)                 started_q <= 1'b1;
    end

    // Sticky underflow: a new starvation wins over a frame_start release.
    always_ff @(posedge clk) begin
        if (!rst_n)                        uf_flag <= 1'b0;
        else if (starve && uf_trig)        uf_flag <= 1'b1;
        else if (frame_start || clear_all) uf_flag <= 1'b0;
    end

    // Registered pixel output; zero when nothing was popped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
        end else begin
            pix_valid <= slot;
            pix_data  <= pop ? packed_pix : '0;
        end
    end

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !frame_start && !clear_all) |=> uf_flag); // R8
    AST_UF_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_flag |=> (pix_data == '0)); // R8
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cfg && !started_q) |=> (pix_data == '0 && !pix_valid)); // R7
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pix_valid); // R11
endmodule

// File: rtl/pixfifo_ctrl.sv
// Top of the format-aware pixel FIFO: byte store, format decode and pixel
// gate. Raises fetch_req while the level is below the format's request
// level. Single clock; register-to-pixel clock crossing is outside.
module pixfifo_ctrl #(
    parameter int DEPTH  = 64,
    parameter int LAT    = 6,
    parameter int BYTE_W = 8,
    parameter int TAPS   = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PIX_W = TAPS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_fifo_clear,
    input  logic              cfg_clear_at_frame,
    input  logic              cfg_wait_hstart,
    input  logic              cfg_uf_trigger,
    input  logic [2:0]        cfg_format,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_byte,
    output logic              fetch_req,
    output logic [CNT_W-1:0]  fifo_level,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              video_active,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              underflow_sticky
);
    logic [CNT_W-1:0] full_level;
    logic [1:0]       pix_bytes;
    logic             flush;
    logic             pop;
    logic [PIX_W-1:0] taps;

    assign flush     = cfg_fifo_clear || (frame_start && cfg_clear_at_frame);
    assign fetch_req = cfg_enable && !cfg_fifo_clear && (fifo_level < full_level);

    pfc_fmt_decode #(.DEPTH(DEPTH), .LAT(LAT), .CNT_W(CNT_W)) u_fmt (
        .fmt        (cfg_format),
        .full_level (full_level),
        .pix_bytes  (pix_bytes)
    );

    pfc_byte_ring #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .TAPS(TAPS), .CNT_W(CNT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (src_valid && cfg_enable),
        .push_byte (src_byte),
        .pop       (pop),
        .pop_bytes (pix_bytes),
        .count     (fifo_level),
        .taps      (taps)
    );

    pfc_pixel_gate #(.PIX_W(PIX_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .clear_all   (cfg_fifo_clear),
        .flush       (flush),
        .wait_cfg    (cfg_wait_hstart),
        .uf_trig     (cfg_uf_trigger),
        .frame_start (frame_start),
        .line_start  (line_start),
        .active      (video_active),
        .have_pixel  (fifo_level >= CNT_W'(pix_bytes)),
        .pix_bytes   (pix_bytes),
        .taps        (taps),
        .pop         (pop),
        .pix_valid   (pix_valid),
        .pix_data    (pix_data),
        .uf_flag     (underflow_sticky)
    );

    AST_FETCH_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !fetch_req); // R11
    AST_FETCH_DROPS_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == CNT_W'(DEPTH)) |-> !fetch_req); // R2
endmodule

// File: tb/pixfifo_ctrl_test.sv
// Directed bench: inputs change just after a falling edge, results are
// read at the following falling edge.
module pixfifo_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 0, cfg_fifo_clear = 0, cfg_clear_at_frame = 0;
    logic        cfg_wait_hstart = 0, cfg_uf_trigger = 0;
    logic [2:0]  cfg_format = 3'd3;
    logic        src_valid = 0;
    logic [7:0]  src_byte = 0;
    logic        fetch_req;
    logic [6:0]  fifo_level;
    logic        frame_start = 0, line_start = 0, video_active = 0;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        underflow_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixfifo_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_fifo_clear(cfg_fifo_clear), .cfg_clear_at_frame(cfg_clear_at_frame),
        .cfg_wait_hstart(cfg_wait_hstart), .cfg_uf_trigger(cfg_uf_trigger),
        .cfg_format(cfg_format), .src_valid(src_valid), .src_byte(src_byte),
        .fetch_req(fetch_req), .fifo_level(fifo_level), .frame_start(frame_start),
        .line_start(line_start), .video_active(video_active), .pix_valid(pix_valid),
        .pix_data(pix_data), .underflow_sticky(underflow_sticky)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_bytes(input int n, input logic [7:0] first);
        for (int i = 0; i < n; i++) begin
            src_valid = 1'b1;
            src_byte  = first + 8'(i);
            tick();
        end
        src_valid = 1'b0;
    endtask

    task automatic do_clear();
        cfg_fifo_clear = 1'b1;
        tick();
        cfg_fifo_clear = 1'b0;
    endtask

    function automatic int exp_level(input int code);
        if (code < 2) return 52;
        if (code == 2) return 50;
        return 46;
    endfunction

    task automatic t_reset();
        check("R1 level", 32'(fifo_level), 0);
        check("R1 fetch_req", 32'(fetch_req), 0);
        check("R1 pix_valid", 32'(pix_valid), 0);
        check("R1 underflow", 32'(underflow_sticky), 0);
    endtask

    task automatic t_thresholds();
        cfg_enable = 1'b1;
        for (int code = 0; code < 8; code++) begin
            cfg_format = 3'(code);
            do_clear();
            push_bytes(exp_level(code) - 1, 8'h00);
            check("R2 below level", 32'(fetch_req), 1);
            check("R3 level count", 32'(fifo_level), 32'(exp_level(code) - 1));
            push_bytes(1, 8'h00);
            check("R2 at level", 32'(fetch_req), 0);
        end
    endtask

    task automatic t_overflow();
        do_clear();
        push_bytes(70, 8'h00);
        check("R3 saturate", 32'(fifo_level), 64);
    endtask

    task automatic t_packing();
        do_clear();
        cfg_format = 3'd3;
        push_bytes(6, 8'h11);
        video_active = 1'b1; tick();
        check("R4 pix24 valid", 32'(pix_valid), 1);
        check("R4 pix24 a", 32'(pix_data), 32'h131211);
        tick(); video_active = 1'b0;
        check("R4 pix24 b", 32'(pix_data), 32'h161514);
        check("R4 level 24", 32'(fifo_level), 0);
        cfg_format = 3'd0;
        push_bytes(4, 8'hA1);
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R4 pix16", 32'(pix_data), 32'h00A2A1);
        check("R4 level 16", 32'(fifo_level), 2);
    endtask

    task automatic t_reset_sequence();
        do_clear();
        push_bytes(5, 8'h30);
        cfg_enable = 1'b0; tick();
        cfg_enable = 1'b1; cfg_fifo_clear = 1'b1; tick();
        cfg_enable = 1'b0; cfg_fifo_clear = 1'b0; tick();
        check("R5 seq level", 32'(fifo_level), 0);
        check("R5 seq fetch", 32'(fetch_req), 0);
        cfg_enable = 1'b1;
    endtask

    task automatic t_disabled();
        do_clear();
        cfg_format = 3'd3;
        push_bytes(4, 8'h71);
        cfg_enable = 1'b0; src_valid = 1'b1; src_byte = 8'hEE; video_active = 1'b1;
        tick(); tick();
        check("R11 level kept", 32'(fifo_level), 4);
        check("R11 no pix", 32'(pix_valid), 0);
        check("R11 no fetch", 32'(fetch_req), 0);
        src_valid = 1'b0; video_active = 1'b0; cfg_enable = 1'b1; tick();
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R11 contents kept", 32'(pix_data), 32'h737271);
    endtask

    task automatic t_frame_clear();
        do_clear();
        push_bytes(10, 8'h00);
        cfg_clear_at_frame = 1'b1; frame_start = 1'b1; src_valid = 1'b1; tick();
        check("R6 frame clears", 32'(fifo_level), 0);
        cfg_clear_at_frame = 1'b0; frame_start = 1'b0; src_valid = 1'b0;
        push_bytes(10, 8'h00);
        frame_start = 1'b1; src_valid = 1'b1; tick();
        frame_start = 1'b0; src_valid = 1'b0;
        check("R6 frame keeps", 32'(fifo_level), 11);
    endtask

    task automatic t_wait_hstart();
        cfg_wait_hstart = 1'b1;
        do_clear();
        cfg_format = 3'd3;
        push_bytes(6, 8'h41);
        video_active = 1'b1; tick(); tick();
        check("R7 held valid", 32'(pix_valid), 0);
        check("R7 held level", 32'(fifo_level), 6);
        check("R7 no underflow", 32'(underflow_sticky), 0);
        line_start = 1'b1; tick(); line_start = 1'b0;
        check("R7 line_start cycle", 32'(fifo_level), 6);
        tick(); video_active = 1'b0;
        check("R7 released valid", 32'(pix_valid), 1);
        check("R7 released data", 32'(pix_data), 32'h434241);
        cfg_wait_hstart = 1'b0;
    endtask

    task automatic t_underflow_trigger();
        cfg_uf_trigger = 1'b1;
        do_clear();
        cfg_format = 3'd3;
        push_bytes(2, 8'h21);
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R8 set", 32'(underflow_sticky), 1);
        check("R8 zero pix", 32'(pix_data), 0);
        push_bytes(6, 8'h23);
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R8 blanked", 32'(pix_data), 0);
        check("R8 no pop", 32'(fifo_level), 8);
        frame_start = 1'b1; tick(); frame_start = 1'b0;
        check("R8 frame releases", 32'(underflow_sticky), 0);
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R8 resume data", 32'(pix_data), 32'h232221);
        check("R8 resume level", 32'(fifo_level), 5);
        cfg_uf_trigger = 1'b0;
    endtask

    task automatic t_underflow_quiet();
        do_clear();
        cfg_format = 3'd0;
        push_bytes(1, 8'h61);
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R9 valid", 32'(pix_valid), 1);
        check("R9 zero", 32'(pix_data), 0);
        check("R9 no flag", 32'(underflow_sticky), 0);
        push_bytes(1, 8'h62);
        video_active = 1'b1; tick(); video_active = 1'b0;
        check("R9 resumes", 32'(pix_data), 32'h006261);
    endtask

    task automatic t_push_pop();
        do_clear();
        cfg_format = 3'd3;
        push_bytes(6, 8'h51);
        video_active = 1'b1; src_valid = 1'b1; src_byte = 8'h57; tick();
        video_active = 1'b0; src_valid = 1'b0;
        check("R10 level", 32'(fifo_level), 4);
        check("R10 data", 32'(pix_data), 32'h535251);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_thresholds();
        t_overflow();
        t_packing();
        t_reset_sequence();
        t_disabled();
        t_frame_clear();
        t_wait_hstart();
        t_underflow_trigger();
        t_underflow_quiet();
        t_push_pop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule